// File: doc/BRIEF.md
# Serial Voltage-Control Slave Without Chip Select

This block is the regulator-side endpoint of a three-wire serial link that a processor or FPGA uses to move its own supply rail. The master drives a bus clock and a command line. The block answers on a single response line. There is no select wire. The block finds each 32-bit command frame by hunting for a two-bit start pattern. It accepts the frame only when a 3-bit CRC in the last bits matches. It then writes, reads or resets the target voltage, or reads the load current.

The bus clock runs far slower than the system clock `clk`. Bus clock and command data are synchronised into the `clk` domain, and bus-clock edges are found there. The reply to a frame is shifted out during the next frame, so replies are one frame behind. Every reply carries a fault flag, a settled flag and a CRC-error flag. The target register stands in for the power stage, together with a settle timer. Requested targets are clamped to the limits set from the management side. A dedicated command forces a safe nominal level. When the master stops the bus clock between frames, the response line shows the settled flag, so the master can wait for it without clocking.

Top module: `vscale_slave`

## Requirements
- R1: A frame begins at the first sampled pair 0 then 1; bits received before that pair are discarded, and the frame is the 32 bits starting at that 0, most significant first.
- R2: Command bits are sampled on falling bus-clock edges and reply bits change after rising edges; the reply to a frame leaves most significant bit first during the following 32-bit frame.
- R3: Bits 2:0 of every frame in both directions hold the CRC over bits 31:3, polynomial x^3+x+1, initial value 0, most significant bit first.
- R4: A command frame with a wrong CRC changes nothing, and bit 29 of its reply is 1 (0 otherwise).
- R5: Command code in bits 29:28: 00 writes the target from bits 23:8, 01 reads the target, 10 goes to nominal, 11 reads `iout_i`; the reply data field (bits 23:8) holds `iout_i` for code 11 and the target after execution otherwise.
- R6: A written value below `vmin_i` becomes `vmin_i`; above `vmax_i` it becomes `vmax_i`.
- R7: The nominal command sets the target to parameter `VNOM` whatever the limits are.
- R8: Reply layout: bit 31 = `fault_i`, bit 30 = settled flag, bit 29 = CRC error, bits 28:27 = received command code, bits 26:24 and 7:3 zero.
- R9: A write or nominal command clears the settled flag; it reads 0 in that command's reply, and `vgood_o` returns to 1 `SETTLE_CYC` clock cycles later.
- R10: When no frame is in progress and no bus-clock edge has been seen for `IDLE_CYC` clock cycles, `sdata_o` follows the settled flag.
- R11: After reset the target is `VNOM`, `vgood_o` is 1, `sdata_o` is 0, and the first reply is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk_i | input | 1 | Serial bus clock from the master, idle low |
| mdata_i | input | 1 | Command data from the master |
| sdata_o | output | 1 | Reply data to the master |
| vmin_i | input | 16 | Lowest target that may be applied |
| vmax_i | input | 16 | Highest target that may be applied |
| fault_i | input | 1 | Fault indication from the power stage |
| iout_i | input | 16 | Load current reading from the power stage |
| vout_o | output | 16 | Applied target voltage code |
| vgood_o | output | 1 | Settled flag |

## Verification
Each bus-clock edge takes three clock cycles to reach the edge pulses. A frame's command is applied two cycles after its last falling edge, and the reply is loaded one cycle later. A reply bit reaches `sdata_o` one cycle after the rising-edge pulse. The bench holds each bus-clock half-period for eight clock cycles. It samples a reply bit just before it drives the falling edge, and checks `vout_o` eight cycles after that edge, so every result has long settled before it is read. The settled-flag checks sit well clear of both timers: 60 cycles after a write, `IDLE_CYC` has passed but `SETTLE_CYC` has not, and 360 cycles after it both have.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
  localparam int FRAME_W   = 32;
  localparam int CRC_W     = 3;
  localparam int DATA_W    = 16;
  localparam int BIT_IDX_W = $clog2(FRAME_W);
  localparam int BODY_W    = FRAME_W - CRC_W;

  // field positions decoded by both ends of the link
  localparam int CMD_HI  = 29;
  localparam int CMD_LO  = 28;
  localparam int DATA_HI = 23;
  localparam int DATA_LO = 8;

  typedef enum logic [1:0] {
    CMD_WRITE   = 2'b00,
    CMD_READV   = 2'b01,
    CMD_NOMINAL = 2'b10,
    CMD_READI   = 2'b11
  } cmd_e;

  // serial CRC, polynomial x^3+x+1, zero seed, MSB first
  function automatic logic [CRC_W-1:0] crc3(input logic [BODY_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = BODY_W - 1; i >= 0; i--) begin
      fb = c[2] ^ d[i];
      c  = {c[1], c[0] ^ fb, fb};
    end
    return c;
  endfunction
endpackage

// File: rtl/vsc_bus_sync.sv
module vsc_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_clk_i,
  input  logic mdata_i,
  output logic rise_o,
  output logic fall_o,
  output logic bit_o
);
  logic [STAGES-1:0] clk_sr;
  logic [STAGES-1:0] dat_sr;
  logic              clk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sr   <= '0;
      dat_sr   <= '0;
      clk_prev <= 1'b0;
      rise_o   <= 1'b0;
      fall_o   <= 1'b0;
      bit_o    <= 1'b0;
    end else begin
      clk_sr   <= {clk_sr[STAGES-2:0], bus_clk_i};
      dat_sr   <= {dat_sr[STAGES-2:0], mdata_i};
      clk_prev <= clk_sr[STAGES-1];
      rise_o   <= clk_sr[STAGES-1] & ~clk_prev;
      fall_o   <= ~clk_sr[STAGES-1] & clk_prev;
      bit_o    <= dat_sr[STAGES-1];
    end
  end

  assert_edges_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(rise_o && fall_o));
endmodule

// File: rtl/vsc_frame_rx.sv
module vsc_frame_rx
  import vsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_i,
  input  logic              bit_i,
  output logic              vld_o,
  output logic [1:0]        cmd_o,
  output logic [DATA_W-1:0] data_o,
  output logic              crc_ok_o,
  output logic              busy_o
);
  localparam logic [BIT_IDX_W-1:0] LAST_IDX = BIT_IDX_W'(FRAME_W - 1);

  logic [BIT_IDX_W-1:0] idx_q;
  logic [FRAME_W-2:0]   sh_q;
  logic [FRAME_W-1:0]   word_d;

  assign word_d = {sh_q, bit_i};
  assign busy_o = (idx_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      sh_q     <= '0;
      vld_o    <= 1'b0;
      cmd_o    <= '0;
      data_o   <= '0;
      crc_ok_o <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (fall_i) begin
        sh_q <= word_d[FRAME_W-2:0];
        if (idx_q == '0) begin
          // hunting: a 0 may open the start pattern
          if (!bit_i) idx_q <= BIT_IDX_W'(1);
        end else if (idx_q == BIT_IDX_W'(1)) begin
          // a further 0 restarts the pattern in place
          if (bit_i) idx_q <= BIT_IDX_W'(2);
        end else if (idx_q == LAST_IDX) begin
          idx_q    <= '0;
          vld_o    <= 1'b1;
          cmd_o    <= word_d[CMD_HI:CMD_LO];
          data_o   <= word_d[DATA_HI:DATA_LO];
          crc_ok_o <= (crc3(word_d[FRAME_W-1:CRC_W]) == word_d[CRC_W-1:0]);
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assert_frame_on_fall_R1: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> $past(fall_i));
  assert_frame_ends_idle_R1: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> !busy_o);
endmodule

// File: rtl/vsc_vreg.sv
module vsc_vreg
  import vsc_pkg::*;
#(
  parameter int                SETTLE_CYC = 200,
  parameter logic [DATA_W-1:0] VNOM       = 16'h0320
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vld_i,
  input  logic [1:0]         cmd_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               crc_ok_i,
  input  logic [DATA_W-1:0]  vmin_i,
  input  logic [DATA_W-1:0]  vmax_i,
  input  logic               fault_i,
  input  logic [DATA_W-1:0]  iout_i,
  output logic [DATA_W-1:0]  vout_o,
  output logic               vgood_o,
  output logic               resp_vld_o,
  output logic [FRAME_W-1:0] resp_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);

  cmd_e              cmd;
  logic [DATA_W-1:0] clamped;
  logic              exec_wr;
  logic              exec_nom;
  logic              change;
  logic [DATA_W-1:0] vout_nxt;
  logic [DATA_W-1:0] rdata;
  logic [BODY_W-1:0] body;
  logic [CNT_W-1:0]  cnt_q;

  always_comb begin
    cmd = cmd_e'(cmd_i);
    if (data_i < vmin_i)      clamped = vmin_i;
    else if (data_i > vmax_i) clamped = vmax_i;
    else                      clamped = data_i;
    exec_wr  = vld_i && crc_ok_i && (cmd == CMD_WRITE);
    exec_nom = vld_i && crc_ok_i && (cmd == CMD_NOMINAL);
    change   = exec_wr || exec_nom;
    if (exec_wr)       vout_nxt = clamped;
    else if (exec_nom) vout_nxt = VNOM;
    else               vout_nxt = vout_o;
    rdata = (cmd == CMD_READI) ? iout_i : vout_nxt;
    body  = {fault_i, (vgood_o && !change), !crc_ok_i, cmd_i, 3'b000, rdata, 5'b00000};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vout_o     <= VNOM;
      vgood_o    <= 1'b1;
      cnt_q      <= '0;
      resp_vld_o <= 1'b0;
      resp_o     <= '0;
    end else begin
      resp_vld_o <= vld_i;
      if (vld_i) resp_o <= {body, crc3(body)};
      vout_o <= vout_nxt;
      if (change) begin
        cnt_q   <= CNT_W'(SETTLE_CYC);
        vgood_o <= 1'b0;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) vgood_o <= 1'b1;
      end
    end
  end

  assert_bad_crc_no_effect_R4: assert property (@(posedge clk) disable iff (rst)
    (vld_i && !crc_ok_i) |=> $stable(vout_o));
  assert_clamp_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    (vld_i && crc_ok_i && cmd_i == 2'b00 && vmin_i <= vmax_i)
      |=> (vout_o >= $past(vmin_i) && vout_o <= $past(vmax_i)));
  assert_nominal_level_R7: assert property (@(posedge clk) disable iff (rst)
    (vld_i && crc_ok_i && cmd_i == 2'b10) |=> (vout_o == VNOM));
  assert_vgood_drops_R9: assert property (@(posedge clk) disable iff (rst)
    (vld_i && crc_ok_i && !cmd_i[0]) |=> !vgood_o);
  assert_vgood_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (!vld_i && $past(!vld_i) && $stable(vout_o)) |-> !$fell(vgood_o));
endmodule

// File: rtl/vsc_resp_tx.sv
module vsc_resp_tx
  import vsc_pkg::*;
#(
  parameter int IDLE_CYC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               busy_i,
  input  logic               resp_vld_i,
  input  logic [FRAME_W-1:0] resp_i,
  input  logic               vgood_i,
  output logic               sdata_o
);
  localparam int IW = $clog2(IDLE_CYC + 1);

  logic [FRAME_W-1:0] sh_q;
  logic [IW-1:0]      idle_q;
  logic               quiet;

  assign quiet = (idle_q == IW'(IDLE_CYC)) && !busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      idle_q  <= '0;
      sdata_o <= 1'b0;
    end else begin
      if (rise_i || fall_i)          idle_q <= '0;
      else if (idle_q != IW'(IDLE_CYC)) idle_q <= idle_q + 1'b1;

      if (resp_vld_i) begin
        sh_q <= resp_i;
      end else if (rise_i) begin
        sdata_o <= sh_q[FRAME_W-1];
        sh_q    <= {sh_q[FRAME_W-2:0], 1'b0};
      end
      if (quiet && !rise_i) sdata_o <= vgood_i;
    end
  end

  assert_load_reply_R2: assert property (@(posedge clk) disable iff (rst)
    resp_vld_i |=> (sh_q == $past(resp_i)));
  assert_shift_msb_R2: assert property (@(posedge clk) disable iff (rst)
    (rise_i && !resp_vld_i) |=> (sdata_o == $past(sh_q[FRAME_W-1])));
  assert_idle_shows_vgood_R10: assert property (@(posedge clk) disable iff (rst)
    (quiet && !rise_i) |=> (sdata_o == $past(vgood_i)));
endmodule

// File: rtl/vscale_slave.sv
module vscale_slave
  import vsc_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter int                SETTLE_CYC  = 200,
  parameter int                IDLE_CYC    = 32,
  parameter logic [DATA_W-1:0] VNOM        = 16'h0320
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_clk_i,
  input  logic              mdata_i,
  output logic              sdata_o,
  input  logic [DATA_W-1:0] vmin_i,
  input  logic [DATA_W-1:0] vmax_i,
  input  logic              fault_i,
  input  logic [DATA_W-1:0] iout_i,
  output logic [DATA_W-1:0] vout_o,
  output logic              vgood_o
);
  logic               rise, fall, rx_bit;
  logic               fvld, fok, busy;
  logic [1:0]         fcmd;
  logic [DATA_W-1:0]  fdata;
  logic               rvld;
  logic [FRAME_W-1:0] rword;

  vsc_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bus_clk_i(bus_clk_i), .mdata_i(mdata_i),
    .rise_o(rise), .fall_o(fall), .bit_o(rx_bit));

  vsc_frame_rx u_rx (
    .clk(clk), .rst(rst), .fall_i(fall), .bit_i(rx_bit),
    .vld_o(fvld), .cmd_o(fcmd), .data_o(fdata), .crc_ok_o(fok), .busy_o(busy));

  vsc_vreg #(.SETTLE_CYC(SETTLE_CYC), .VNOM(VNOM)) u_vreg (
    .clk(clk), .rst(rst), .vld_i(fvld), .cmd_i(fcmd), .data_i(fdata),
    .crc_ok_i(fok), .vmin_i(vmin_i), .vmax_i(vmax_i), .fault_i(fault_i),
    .iout_i(iout_i), .vout_o(vout_o), .vgood_o(vgood_o),
    .resp_vld_o(rvld), .resp_o(rword));

  vsc_resp_tx #(.IDLE_CYC(IDLE_CYC)) u_tx (
    .clk(clk), .rst(rst), .rise_i(rise), .fall_i(fall), .busy_i(busy),
    .resp_vld_i(rvld), .resp_i(rword), .vgood_i(vgood_o), .sdata_o(sdata_o));
endmodule

// File: tb/test_vscale_slave.sv
module test_vscale_slave;
  localparam int HP = 8;
  localparam int SETTLE = 200;
  localparam int IDLE = 32;
  localparam logic [15:0] VNOM = 16'h0320;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk = 1'b0, mdata = 1'b0;
  logic sdata, vgood, fault = 1'b0;
  logic [15:0] vmin = 16'h0200, vmax = 16'h0500, iout = 16'h1234, vout;

  int checks = 0, failures = 0;
  logic [31:0] exp_resp = '0;
  logic [15:0] vout_m = VNOM;

  always #2 clk = ~clk;

  vscale_slave #(.SETTLE_CYC(SETTLE), .IDLE_CYC(IDLE), .VNOM(VNOM)) i_vscale_slave (
    .clk(clk), .rst(rst), .bus_clk_i(bclk), .mdata_i(mdata), .sdata_o(sdata),
    .vmin_i(vmin), .vmax_i(vmax), .fault_i(fault), .iout_i(iout),
    .vout_o(vout), .vgood_o(vgood));

  // remainder of {d,000} divided by 1011
  function automatic logic [2:0] tb_crc(input logic [28:0] d);
    logic [31:0] r;
    r = {d, 3'b000};
    for (int i = 31; i >= 3; i--)
      if (r[i]) r[i -: 4] = r[i -: 4] ^ 4'b1011;
    return r[2:0];
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] cmd, input logic [15:0] d);
    logic [28:0] b;
    b = {2'b01, cmd, 4'b0000, d, 5'b00000};
    return {b, tb_crc(b)};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_bit(input logic b, output logic s);
    @(negedge clk);
    mdata = b;
    bclk  = 1'b1;
    repeat (HP) @(negedge clk);
    s    = sdata;
    bclk = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  // model the effect of a frame the block will accept
  task automatic model(input logic [31:0] w);
    logic ok, wrote;
    logic [1:0] c;
    logic [15:0] d, rd;
    logic [28:0] b;
    ok = (tb_crc(w[31:3]) == w[2:0]);
    c = w[29:28];
    d = w[23:8];
    wrote = 1'b0;
    if (ok && c == 2'b00) begin
      vout_m = (d < vmin) ? vmin : (d > vmax) ? vmax : d;
      wrote = 1'b1;
    end else if (ok && c == 2'b10) begin
      vout_m = VNOM;
      wrote = 1'b1;
    end
    rd = (c == 2'b11) ? iout : vout_m;
    b = {fault, !wrote, !ok, c, 3'b000, rd, 5'b00000};
    exp_resp = {b, tb_crc(b)};
  endtask

  task automatic frame(input logic [31:0] w, input logic check_resp);
    logic [31:0] got;
    for (int k = 31; k >= 0; k--) bus_bit(w[k], got[k]);
    if (check_resp) begin
      chk(got == exp_resp, "R2 R8 reply word", got, exp_resp);
      chk(got[2:0] == tb_crc(got[31:3]), "R3 reply crc", {29'd0, got[2:0]}, {29'd0, tb_crc(got[31:3])});
    end
    model(w);
    chk(vout == vout_m, "R5 R6 R7 target", {16'd0, vout}, {16'd0, vout_m});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog got=%h exp=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic s;
    logic [31:0] w;
    void'($urandom(32'h5eed1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(vout == VNOM, "R11 reset target", {16'd0, vout}, {16'd0, VNOM});
    chk(vgood == 1'b1, "R11 reset vgood", {31'd0, vgood}, 32'd1);
    chk(sdata == 1'b0, "R11 reset sdata", {31'd0, sdata}, 32'd0);

    // R5 write in range, first reply all zeros (R11)
    frame(mk(2'b00, 16'h0400), 1'b1);
    // R9 R10: clock stopped, flag low then high
    repeat (52) @(negedge clk);
    chk(vgood == 1'b0, "R9 vgood low after write", {31'd0, vgood}, 32'd0);
    chk(sdata == 1'b0, "R10 idle line shows low vgood", {31'd0, sdata}, 32'd0);
    repeat (300) @(negedge clk);
    chk(vgood == 1'b1, "R9 vgood back", {31'd0, vgood}, 32'd1);
    chk(sdata == 1'b1, "R10 idle line shows vgood", {31'd0, sdata}, 32'd1);

    // R6 clamping both ways
    frame(mk(2'b00, 16'h0010), 1'b1);
    frame(mk(2'b00, 16'hFFFF), 1'b1);
    // R5 reads, R8 fault bit
    frame(mk(2'b01, 16'h0000), 1'b1);
    fault = 1'b1;
    iout  = 16'hBEEF;
    frame(mk(2'b11, 16'h0000), 1'b1);
    fault = 1'b0;
    // R4 bad CRC write
    w = mk(2'b00, 16'h0300);
    w[1] = ~w[1];
    frame(w, 1'b1);
    frame(mk(2'b01, 16'h0000), 1'b1);
    // R7 nominal with VNOM below vmin
    vmin = 16'h0400;
    frame(mk(2'b10, 16'h0000), 1'b1);
    vmin = 16'h0200;
    // R1 junk bits before the start pattern; reply of this span is skewed
    bus_bit(1'b1, s);
    bus_bit(1'b1, s);
    bus_bit(1'b0, s);
    bus_bit(1'b0, s);
    frame(mk(2'b00, 16'h0444), 1'b0);
    chk(vout == 16'h0444, "R1 frame found after junk", {16'd0, vout}, 32'h0444);
    frame(mk(2'b01, 16'h0000), 1'b1);

    // random traffic
    for (int n = 0; n < 60; n++) begin
      vmin  = 16'($urandom_range(0, 16'h7fff));
      vmax  = vmin + 16'($urandom_range(0, 16'h7fff));
      fault = 1'($urandom_range(0, 1));
      iout  = 16'($urandom);
      w = mk(2'($urandom_range(0, 3)), 16'($urandom));
      if ($urandom_range(0, 7) == 0) w[0] = ~w[0];
      frame(w, 1'b1);
    end
    frame(mk(2'b01, 16'h0000), 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule